// File: doc/BRIEF.md
# Eight-Output Addressable Latch and Demultiplexer

This block holds eight storage bits behind one serial data input. A binary address picks one output position. Two active-low controls, a write-enable and a clear, choose among four modes. In selective write mode only the picked bit is transparent to the data input. In hold mode every bit keeps its value. In steering mode the data goes to the picked output and all other outputs are low. In clear mode every output is low. The storage is level-sensitive and has no clock, so every response follows the inputs directly.

The usual sequence is as follows. Park the block in hold mode, move the address to the next target, then pulse the write-enable low to update that single bit. Changing the address while a bit is transparent can briefly select the wrong position. Address moves are therefore made in hold mode only.

Top module: `addr_latch_demux`

## Requirements
- R1: Address value k (0 to 7) selects output bit q_out[k], so address 0 acts on q_out[0] and address 7 acts on q_out[7].
- R2: With wr_en_n=0 and clr_n=1 (selective write mode), the selected output equals d_in, non-inverted, and follows it while the mode lasts.
- R3: In selective write mode, every output that is not selected keeps the value it held before.
- R4: With wr_en_n=1 and clr_n=1 (hold mode), all eight outputs keep their values whatever d_in and sel_addr do.
- R5: With wr_en_n=0 and clr_n=0 (steering mode), the selected output equals d_in and all other outputs are 0.
- R6: With wr_en_n=1 and clr_n=0 (clear mode), all outputs are 0 whatever d_in and sel_addr are, with no clock involved.
- R7: Address changes made in hold mode leave every stored bit unchanged, and a following selective write acts only on the new address.
- R8: On a move from steering mode to hold mode, each bit keeps the value it showed at that moment: d_in at the selected position and 0 everywhere else.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_en_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low clear |
| sel_addr | input | ADDR_W (3) | Binary output selector |
| d_in | input | 1 | Data value for the selected bit |
| q_out | output | 2**ADDR_W (8) | Stored or steered bits, non-inverted |

## Verification
The hardest case to reach from the ports is a bit that has been built up by several separate selective writes and then has to stay intact while the address moves to every other position and the data input toggles. The stimulus builds such a pattern one address at a time. It then moves through all addresses and data values in hold mode. After that it rewrites one position and checks that only that position changed. The exits from steering and clear modes into hold mode are covered in the same way, each followed by hold-mode stimulus that could disturb the stored bits.

// File: rtl/alatch_pkg.sv
package alatch_pkg;

   typedef enum logic [1:0] {
      MODE_WRITE = 2'b00,
      MODE_HOLD  = 2'b01,
      MODE_STEER = 2'b10,
      MODE_CLEAR = 2'b11
   } alatch_mode_e;

   // Mode from the two active-low controls.
   function automatic alatch_mode_e mode_of(input logic wr_en_n, input logic clr_n);
      alatch_mode_e m;
      case ({wr_en_n, clr_n})
         2'b01:   m = MODE_WRITE;
         2'b11:   m = MODE_HOLD;
         2'b00:   m = MODE_STEER;
         default: m = MODE_CLEAR;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/alatch_mode_dec.sv
module alatch_mode_dec
   import alatch_pkg::*;
(
   input  logic         wr_en_n,
   input  logic         clr_n,
   output alatch_mode_e mode,
   output logic         open_sel,
   output logic         wipe
);
   always_comb begin
      mode     = mode_of(wr_en_n, clr_n);
      open_sel = (mode == MODE_WRITE) || (mode == MODE_STEER);
      wipe     = (mode == MODE_STEER) || (mode == MODE_CLEAR);
   end
endmodule

// File: rtl/alatch_addr_dec.sv
module alatch_addr_dec #(
   parameter int ADDR_W    = 3,
   parameter int DEC_STYLE = 0,
   localparam int NUM_OUT  = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [NUM_OUT-1:0] sel
);
   initial begin
      AST_DEC_STYLE_OK: assert (DEC_STYLE == 0 || DEC_STYLE == 1)
         else $error("alatch_addr_dec: DEC_STYLE must be 0 or 1");
   end

   generate
      if (DEC_STYLE == 0) begin : g_cmp
         for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
            assign sel[i] = (addr == ADDR_W'(i));
         end
      end else begin : g_shift
         assign sel = NUM_OUT'(1) << addr;
      end
   endgenerate

   always_comb begin
      if (!$isunknown(addr)) begin
         AST_SEL_ONEHOT: assert ($onehot(sel) && sel[addr]) else $error("selector not one-hot at address"); // R1
      end
   end
endmodule

// File: rtl/alatch_cell_array.sv
module alatch_cell_array #(
   parameter int NUM_OUT = 8
) (
   input  logic [NUM_OUT-1:0] sel,
   input  logic               open_sel,
   input  logic               wipe,
   input  logic               d_in,
   output logic [NUM_OUT-1:0] st
);
   generate
      for (genvar i = 0; i < NUM_OUT; i++) begin : g_cell
         logic bit_r;
         always_latch begin
            if (wipe)
               bit_r <= open_sel & sel[i] & d_in;
            else if (open_sel & sel[i])
               bit_r <= d_in;
         end
         assign st[i] = bit_r;
      end
   endgenerate
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
   import alatch_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int DEC_STYLE = 0,
   localparam int NUM_OUT  = 1 << ADDR_W
) (
   input  logic               wr_en_n,
   input  logic               clr_n,
   input  logic [ADDR_W-1:0]  sel_addr,
   input  logic               d_in,
   output logic [NUM_OUT-1:0] q_out
);
   initial begin
      AST_ADDR_W_RANGE: assert (ADDR_W >= 1 && ADDR_W <= 6)
         else $error("addr_latch_demux: ADDR_W out of range");
   end

   alatch_mode_e       mode;
   logic               open_sel;
   logic               wipe;
   logic [NUM_OUT-1:0] sel;

   alatch_mode_dec u_mode (
      .wr_en_n (wr_en_n),
      .clr_n   (clr_n),
      .mode    (mode),
      .open_sel(open_sel),
      .wipe    (wipe)
   );

   alatch_addr_dec #(.ADDR_W(ADDR_W), .DEC_STYLE(DEC_STYLE)) u_dec (
      .addr(sel_addr),
      .sel (sel)
   );

   alatch_cell_array #(.NUM_OUT(NUM_OUT)) u_cells (
      .sel     (sel),
      .open_sel(open_sel),
      .wipe    (wipe),
      .d_in    (d_in),
      .st      (q_out)
   );

   always_comb begin
      if (!$isunknown({wr_en_n, clr_n, sel_addr, d_in})) begin
         if (mode == MODE_CLEAR) begin
            AST_CLEAR_ALL_LOW: assert (q_out == '0) else $error("clear mode output not zero"); // R6
         end
         if (mode == MODE_STEER) begin
            AST_STEER_ONE_HOT: assert ($countones(q_out) <= 1) else $error("steer mode more than one high"); // R5
            AST_STEER_FOLLOW: assert (q_out[sel_addr] == d_in) else $error("steer mode bit mismatch"); // R5
         end
         if (mode == MODE_WRITE) begin
            AST_WRITE_FOLLOW: assert (q_out[sel_addr] == d_in) else $error("write mode bit mismatch"); // R2
         end
      end
   end
endmodule

// File: tb/addr_latch_demux_tb.sv
module addr_latch_demux_tb;
   logic       clk = 1'b0;
   logic       wr_en_n = 1'b1;
   logic       clr_n = 1'b0;
   logic [2:0] sel_addr = '0;
   logic       d_in = 1'b0;
   logic [7:0] q_out;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] model = '0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   bit         done = 1'b0;

   always #10 clk = ~clk;

   addr_latch_demux u_dut (
      .wr_en_n (wr_en_n),
      .clr_n   (clr_n),
      .sel_addr(sel_addr),
      .d_in    (d_in),
      .q_out   (q_out)
   );

   // mode encoding: {wr_en_n,clr_n} 01 write, 11 hold, 00 steer, 10 clear
   task automatic apply(input logic en, input logic cl, input logic [2:0] a,
                        input logic d, input string tag);
      @(posedge clk);
      wr_en_n  = en;
      clr_n    = cl;
      sel_addr = a;
      d_in     = d;
      case ({en, cl})
         2'b01: model[a] = d;
         2'b11: ;
         2'b00: begin model = '0; model[a] = d; end
         default: model = '0;
      endcase
      exp_q.push_back(model);
      tag_q.push_back(tag);
   endtask

   // monitor: compare half a cycle after inputs change
   always @(negedge clk) begin
      if (exp_q.size() != 0) begin
         logic [7:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_tests++;
         if (q_out !== e) begin
            n_fail++;
            $display("FAIL %s: q_out=%02h expected=%02h", t, q_out, e);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: timeout actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // reset state and clear ignoring inputs
      apply(1, 0, 3'd0, 0, "R6 reset");
      apply(1, 0, 3'd5, 1, "R6");
      apply(1, 0, 3'd7, 1, "R6");
      // build a pattern one bit at a time: R1 R2 R3
      for (int a = 0; a < 8; a++) begin
         apply(1, 1, 3'(a), 0, "R7 move");
         apply(0, 1, 3'(a), (8'hA5 >> a) & 1'b1, "R1 R2 R3");
      end
      // address and data toggles in hold: R4 R7
      for (int a = 0; a < 8; a++)
         for (int d = 0; d < 2; d++)
            apply(1, 1, 3'(a), 1'(d), "R4 R7");
      // follow while transparent: R2
      apply(0, 1, 3'd3, 1, "R2");
      apply(0, 1, 3'd3, 0, "R2");
      apply(0, 1, 3'd3, 1, "R2");
      apply(1, 1, 3'd6, 0, "R4");
      apply(0, 1, 3'd6, 1, "R3 R7");
      // steering: R5, then exit to hold: R8
      for (int a = 0; a < 8; a++)
         for (int d = 0; d < 2; d++)
            apply(0, 0, 3'(a), 1'(d), "R5");
      apply(0, 0, 3'd4, 1, "R5");
      apply(1, 1, 3'd4, 1, "R8");
      apply(1, 1, 3'd0, 0, "R8");
      apply(1, 1, 3'd7, 1, "R8");
      apply(0, 0, 3'd2, 0, "R5");
      apply(1, 1, 3'd2, 1, "R8");
      // clear then hold, then write into cleared bits
      apply(0, 1, 3'd1, 1, "R2");
      apply(1, 0, 3'd1, 1, "R6");
      apply(1, 1, 3'd1, 1, "R6 R4");
      apply(0, 1, 3'd0, 1, "R1 R2");
      apply(0, 1, 3'd7, 1, "R1 R3");
      // every mode, address and data value
      for (int m = 0; m < 4; m++)
         for (int a = 0; a < 8; a++)
            for (int d = 0; d < 2; d++)
               apply(1'(m >> 1), 1'(m), 3'(a), 1'(d),
                     (m == 1) ? "R2 R3" : (m == 3) ? "R4" : (m == 0) ? "R5" : "R6");
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule